// File: doc/BRIEF.md
# Cycle-to-Cycle Jitter Measurement Engine

This engine measures the cycle-to-cycle jitter of a clock under test. The clock under test enters as a data input. A faster, free-running sampling clock samples it through a synchronizer and counts the sampling ticks between consecutive rising edges. Each sample is taken from two adjacent periods, and the value kept is the absolute difference of their lengths. Between samples the engine skips a pseudo-random number of periods of the clock under test.

Samples are grouped into sets. For each set the engine reports the peak difference, the sample count, the sum and the sum of squares, so that software can compute the mean and RMS values. After the last set it reports the average of the per-set peaks. A second mode sums the lengths of a run of contiguous periods with no gaps, which gives an accumulated-jitter figure.

A one-cycle start pulse clears all state and begins a run. The mode input picks between the sampled-jitter run and the accumulated run. The done flag marks the result outputs as final.

Top module: `jit_c2c_engine`

## Requirements
- R1: After reset, and in the cycle after a start pulse, `done_o`, `set_vld_o` and `ovf_o` are 0. After reset, `avg_peak_o` and `lt_span_o` are 0.
- R2: A period is the number of sampling-clock ticks between two consecutive rising edges of the synchronized `clk_ut_i`. The first edge after start only arms the counter. Each sample is |T1 − T2|, where T1 and T2 are two adjacent periods.
- R3: A period longer than 2^CNT_W − 1 ticks is reported as 2^CNT_W − 1, and it sets `ovf_o`. `ovf_o` stays 1 until the next start pulse.
- R4: After every sample except the final sample of the run, the engine skips g whole periods, where g = lfsr[GAP_W-1:0] & `gap_mask_i`. The LFSR is 16 bits wide and loads 0xACE1 on start. After each draw it steps once as a right-shifting Galois register: lsb = s[0]; s = s >> 1; if lsb is 1, s ^= 0xB400. A mask of 0 makes the samples back to back.
- R5: `peak_o` is the largest sample in the set just completed.
- R6: `sum_o` is the sum of that set's samples. `sumsq_o` is the sum of their squares. `count_o` equals SAMPLES.
- R7: `set_vld_o` is a one-cycle pulse once per completed set, and a run produces exactly SETS pulses. The per-set outputs change on that pulse.
- R8: When the last set completes, `avg_peak_o` = floor(sum of per-set peaks / SETS), and `done_o` rises. `done_o` stays 1 until the next start.
- R9: With `long_mode_i` = 1 at start, the engine sums LT_CYCLES contiguous periods (each saturated as in R3) into `lt_span_o`, then raises `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| clk_ut_i | input | 1 | Clock under test, treated as asynchronous data |
| start_i | input | 1 | One-cycle pulse: clear and begin a run |
| long_mode_i | input | 1 | Sampled at start: 1 selects the accumulated run |
| gap_mask_i | input | GAP_W | Mask applied to the random gap |
| set_vld_o | output | 1 | Pulse: per-set results updated |
| peak_o | output | CNT_W | Peak difference of the last set |
| count_o | output | clog2(SAMPLES+1) | Samples in the last set |
| sum_o | output | 2*CNT_W | Sum of differences of the last set |
| sumsq_o | output | 3*CNT_W | Sum of squared differences of the last set |
| avg_peak_o | output | CNT_W | Average of the per-set peaks |
| lt_span_o | output | CNT_W+clog2(LT_CYCLES+1) | Accumulated length of the contiguous periods |
| ovf_o | output | 1 | Sticky period saturation flag |
| done_o | output | 1 | Run complete; results are final |

## Verification
A rising edge on `clk_ut_i` reaches the period counter two sampling edges later, and the finished period is taken in that same cycle. The set statistics update one cycle later. `set_vld_o`, the latched per-set results and, on the last set, `avg_peak_o` and `done_o` appear on the following edge. `lt_span_o` and `done_o` appear one edge after the final contiguous edge is seen.

The bench drives `clk_ut_i` on falling edges with an exactly known tick count per period. It captures per-set results on the falling edge where `set_vld_o` is high. It reads the final results on falling edges once `done_o` is seen. Expected values come from walking the same period sequence arithmetically, including the random gaps.

// File: rtl/jit_pkg.sv
package jit_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_T1, ST_T2, ST_GAP, ST_SETEND, ST_LONG, ST_DONE
  } jit_state_e;

  localparam logic [15:0] LFSR_SEED = 16'hACE1;
  localparam logic [15:0] LFSR_TAPS = 16'hB400;
endpackage

// File: rtl/jit_edge_sync.sv
module jit_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  // STAGES synchronizer flops plus one history flop
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], async_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/jit_period_cnt.sv
module jit_period_cnt #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         edge_i,
  output logic [W-1:0] period_o,
  output logic         vld_o,
  output logic         ovf_o
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  logic [W-1:0] cnt_q;
  logic         armed_q;
  logic         ovf_q;
  logic         sat;

  assign sat      = (cnt_q == MAXV);
  assign period_o = sat ? MAXV : cnt_q + W'(1);
  assign vld_o    = edge_i & armed_q & ~clear_i;
  assign ovf_o    = ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      ovf_q   <= 1'b0;
    end else if (clear_i) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      ovf_q   <= 1'b0;
    end else if (edge_i) begin
      cnt_q   <= '0;
      armed_q <= 1'b1;
      if (armed_q && sat) ovf_q <= 1'b1;
    end else if (!sat) begin
      cnt_q <= cnt_q + W'(1);
    end
  end
endmodule

// File: rtl/jit_lfsr.sv
module jit_lfsr import jit_pkg::*; #(
  parameter int OUT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             step_i,
  output logic [OUT_W-1:0] rnd_o
);
  logic [15:0] s_q;
  logic [15:0] s_nx;

  assign s_nx  = {1'b0, s_q[15:1]} ^ (s_q[0] ? LFSR_TAPS : 16'h0000);
  assign rnd_o = s_q[OUT_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     s_q <= LFSR_SEED;
    else if (load_i) s_q <= LFSR_SEED;
    else if (step_i) s_q <= s_nx;
  end
endmodule

// File: rtl/jit_set_stats.sv
module jit_set_stats #(
  parameter int W     = 16,
  parameter int SUM_W = 32,
  parameter int SQ_W  = 48,
  parameter int N_W   = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             push_i,
  input  logic [W-1:0]     diff_i,
  output logic [W-1:0]     peak_o,
  output logic [SUM_W-1:0] sum_o,
  output logic [SQ_W-1:0]  sumsq_o,
  output logic [N_W-1:0]   count_o
);
  logic [2*W-1:0] sq;
  assign sq = {{W{1'b0}}, diff_i} * {{W{1'b0}}, diff_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      peak_o  <= '0;
      sum_o   <= '0;
      sumsq_o <= '0;
      count_o <= '0;
    end else if (clear_i) begin
      peak_o  <= '0;
      sum_o   <= '0;
      sumsq_o <= '0;
      count_o <= '0;
    end else if (push_i) begin
      if (diff_i > peak_o) peak_o <= diff_i;
      sum_o   <= sum_o + SUM_W'(diff_i);
      sumsq_o <= sumsq_o + SQ_W'(sq);
      count_o <= count_o + N_W'(1);
    end
  end
endmodule

// File: rtl/jit_c2c_engine.sv
module jit_c2c_engine import jit_pkg::*; #(
  parameter  int CNT_W       = 16,
  parameter  int SAMPLES     = 1000,
  parameter  int SETS        = 25,
  parameter  int LT_CYCLES   = 10000,
  parameter  int GAP_W       = 8,
  parameter  int SYNC_STAGES = 2,
  localparam int SUM_W       = 2 * CNT_W,
  localparam int SQ_W        = 3 * CNT_W,
  localparam int SAMP_W      = $clog2(SAMPLES + 1),
  localparam int LT_W        = CNT_W + $clog2(LT_CYCLES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clk_ut_i,
  input  logic              start_i,
  input  logic              long_mode_i,
  input  logic [GAP_W-1:0]  gap_mask_i,
  output logic              set_vld_o,
  output logic [CNT_W-1:0]  peak_o,
  output logic [SAMP_W-1:0] count_o,
  output logic [SUM_W-1:0]  sum_o,
  output logic [SQ_W-1:0]   sumsq_o,
  output logic [CNT_W-1:0]  avg_peak_o,
  output logic [LT_W-1:0]   lt_span_o,
  output logic              ovf_o,
  output logic              done_o
);
  localparam int SET_W  = $clog2(SETS + 1);
  localparam int LTC_W  = $clog2(LT_CYCLES + 1);
  localparam int PACC_W = CNT_W + SET_W;

  jit_state_e        st_q;
  logic              rise;
  logic              pvld;
  logic [CNT_W-1:0]  period;
  logic [CNT_W-1:0]  t1_q;
  logic [CNT_W-1:0]  diff;
  logic [SAMP_W-1:0] samp_q;
  logic [SET_W-1:0]  set_q;
  logic [GAP_W-1:0]  skip_q;
  logic [GAP_W-1:0]  rnd;
  logic [GAP_W-1:0]  gap;
  logic [LTC_W-1:0]  ltc_q;
  logic [LT_W-1:0]   span_q;
  logic [PACC_W-1:0] pacc_q;
  logic [PACC_W-1:0] pacc_nx;
  logic              last_samp;
  logic              last_set;
  logic              push;
  logic              stat_clr;
  logic              draw;
  logic [CNT_W-1:0]  run_peak;
  logic [SUM_W-1:0]  run_sum;
  logic [SQ_W-1:0]   run_sq;
  logic [SAMP_W-1:0] run_cnt;

  jit_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .async_i(clk_ut_i),
    .rise_o(rise)
  );

  jit_period_cnt #(.W(CNT_W)) u_per (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (start_i),
    .edge_i  (rise),
    .period_o(period),
    .vld_o   (pvld),
    .ovf_o   (ovf_o)
  );

  assign diff      = (t1_q >= period) ? (t1_q - period) : (period - t1_q);
  assign last_samp = (samp_q == SAMP_W'(SAMPLES - 1));
  assign last_set  = (set_q == SET_W'(SETS - 1));
  assign push      = (st_q == ST_T2) && pvld;
  assign stat_clr  = start_i || (st_q == ST_SETEND);
  assign draw      = !start_i && ((push && !last_samp) || ((st_q == ST_SETEND) && !last_set));
  assign gap       = rnd & gap_mask_i;
  assign pacc_nx   = pacc_q + PACC_W'(run_peak);

  jit_lfsr #(.OUT_W(GAP_W)) u_lfsr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(start_i),
    .step_i(draw),
    .rnd_o (rnd)
  );

  jit_set_stats #(.W(CNT_W), .SUM_W(SUM_W), .SQ_W(SQ_W), .N_W(SAMP_W)) u_stats (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(stat_clr),
    .push_i (push),
    .diff_i (diff),
    .peak_o (run_peak),
    .sum_o  (run_sum),
    .sumsq_o(run_sq),
    .count_o(run_cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      t1_q       <= '0;
      samp_q     <= '0;
      set_q      <= '0;
      skip_q     <= '0;
      ltc_q      <= '0;
      span_q     <= '0;
      pacc_q     <= '0;
      set_vld_o  <= 1'b0;
      peak_o     <= '0;
      count_o    <= '0;
      sum_o      <= '0;
      sumsq_o    <= '0;
      avg_peak_o <= '0;
      lt_span_o  <= '0;
      done_o     <= 1'b0;
    end else if (start_i) begin
      st_q       <= long_mode_i ? ST_LONG : ST_T1;
      samp_q     <= '0;
      set_q      <= '0;
      skip_q     <= '0;
      ltc_q      <= '0;
      span_q     <= '0;
      pacc_q     <= '0;
      set_vld_o  <= 1'b0;
      peak_o     <= '0;
      count_o    <= '0;
      sum_o      <= '0;
      sumsq_o    <= '0;
      avg_peak_o <= '0;
      lt_span_o  <= '0;
      done_o     <= 1'b0;
    end else begin
      set_vld_o <= 1'b0;
      case (st_q)
        ST_T1: if (pvld) begin
          t1_q <= period;
          st_q <= ST_T2;
        end
        ST_T2: if (pvld) begin
          if (last_samp) begin
            st_q <= ST_SETEND;
          end else begin
            samp_q <= samp_q + SAMP_W'(1);
            skip_q <= gap;
            st_q   <= (gap == '0) ? ST_T1 : ST_GAP;
          end
        end
        ST_GAP: if (pvld) begin
          skip_q <= skip_q - GAP_W'(1);
          if (skip_q == GAP_W'(1)) st_q <= ST_T1;
        end
        ST_SETEND: begin
          peak_o    <= run_peak;
          count_o   <= run_cnt;
          sum_o     <= run_sum;
          sumsq_o   <= run_sq;
          set_vld_o <= 1'b1;
          samp_q    <= '0;
          pacc_q    <= pacc_nx;
          if (last_set) begin
            avg_peak_o <= CNT_W'(pacc_nx / PACC_W'(SETS));
            done_o     <= 1'b1;
            st_q       <= ST_DONE;
          end else begin
            set_q  <= set_q + SET_W'(1);
            skip_q <= gap;
            st_q   <= (gap == '0) ? ST_T1 : ST_GAP;
          end
        end
        ST_LONG: if (pvld) begin
          span_q <= span_q + LT_W'(period);
          if (ltc_q == LTC_W'(LT_CYCLES - 1)) begin
            lt_span_o <= span_q + LT_W'(period);
            done_o    <= 1'b1;
            st_q      <= ST_DONE;
          end else begin
            ltc_q <= ltc_q + LTC_W'(1);
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/jit_c2c_chk.sv
module jit_c2c_chk #(
  parameter int CNT_W   = 16,
  parameter int SAMPLES = 1000
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic                            start_i,
  input logic                            set_vld_o,
  input logic                            done_o,
  input logic                            ovf_o,
  input logic [CNT_W-1:0]                peak_o,
  input logic [2*CNT_W-1:0]              sum_o,
  input logic [3*CNT_W-1:0]              sumsq_o,
  input logic [$clog2(SAMPLES+1)-1:0]    count_o
);
  localparam int SQ_W   = 3 * CNT_W;
  localparam int SAMP_W = $clog2(SAMPLES + 1);

  a_r1_start_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (!done_o && !ovf_o && !set_vld_o));

  a_r3_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !start_i) |=> ovf_o);

  a_r6_sum_covers_peak: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_vld_o |-> (sum_o >= (2*CNT_W)'(peak_o)));

  a_r6_sq_covers_peak: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_vld_o |-> (sumsq_o >= (SQ_W'(peak_o) * SQ_W'(peak_o))));

  a_r6_full_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_vld_o |-> (count_o == SAMP_W'(SAMPLES)));

  a_r7_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_vld_o |=> !set_vld_o);

  a_r8_done_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o);
endmodule

bind jit_c2c_engine jit_c2c_chk #(.CNT_W(CNT_W), .SAMPLES(SAMPLES)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .set_vld_o(set_vld_o),
  .done_o   (done_o),
  .ovf_o    (ovf_o),
  .peak_o   (peak_o),
  .sum_o    (sum_o),
  .sumsq_o  (sumsq_o),
  .count_o  (count_o)
);

// File: tb/tb_jit_c2c_engine.sv
`timescale 1ns/1ps
module tb_jit_c2c_engine;
  localparam int CW   = 8;
  localparam int NS   = 4;
  localparam int NSET = 3;
  localparam int LT   = 6;
  localparam int GW   = 8;
  localparam int SAMP_W = $clog2(NS + 1);
  localparam int LT_W   = CW + $clog2(LT + 1);
  localparam int MAXP   = (1 << CW) - 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              clk_ut = 1'b0;
  logic              start = 1'b0;
  logic              long_mode = 1'b0;
  logic [GW-1:0]     mask = '0;
  logic              set_vld;
  logic [CW-1:0]     peak;
  logic [SAMP_W-1:0] count;
  logic [2*CW-1:0]   sum;
  logic [3*CW-1:0]   sumsq;
  logic [CW-1:0]     avg_peak;
  logic [LT_W-1:0]   lt_span;
  logic              ovf;
  logic              done;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  jit_c2c_engine #(.CNT_W(CW), .SAMPLES(NS), .SETS(NSET), .LT_CYCLES(LT), .GAP_W(GW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .clk_ut_i(clk_ut), .start_i(start),
    .long_mode_i(long_mode), .gap_mask_i(mask), .set_vld_o(set_vld),
    .peak_o(peak), .count_o(count), .sum_o(sum), .sumsq_o(sumsq),
    .avg_peak_o(avg_peak), .lt_span_o(lt_span), .ovf_o(ovf), .done_o(done)
  );

  // per-set capture
  longint cap_peak [0:7];
  longint cap_sum  [0:7];
  longint cap_sq   [0:7];
  longint cap_cnt  [0:7];
  int     cap_n = 0;

  always @(negedge clk) begin
    if (set_vld && cap_n < 8) begin
      cap_peak[cap_n] = peak;
      cap_sum[cap_n]  = sum;
      cap_sq[cap_n]   = sumsq;
      cap_cnt[cap_n]  = count;
      cap_n = cap_n + 1;
    end
  end

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int per(input int pat, input int k);
    case (pat)
      0:       return 8 + (k * 5) % 7;
      1:       return 6 + (k * k + 3 * k) % 11;
      2:       return 9 + k % 3;
      default: return (k == 2) ? 300 : 10;
    endcase
  endfunction

  function automatic int sat(input int p);
    return (p > MAXP) ? MAXP : p;
  endfunction

  task automatic emit(input int p);
    clk_ut = 1'b1;
    repeat (p / 2) @(negedge clk);
    clk_ut = 1'b0;
    repeat (p - p / 2) @(negedge clk);
  endtask

  task automatic run(input int pat, input logic lm, input logic [GW-1:0] m);
    cap_n = 0;
    @(negedge clk);
    long_mode = lm;
    mask      = m;
    start     = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R1 done clear after start", done, 0);
    check("R1 ovf clear after start", ovf, 0);
    repeat (3) @(negedge clk);
    for (int k = 0; k < 3000 && !done; k++) emit(per(pat, k));
    repeat (4) @(negedge clk);
  endtask

  // sampled-mode model: walks periods, gaps and sets arithmetically
  task automatic check_sampled(input int pat, input logic [GW-1:0] m);
    logic [15:0] s;
    int k, pk, sm, sq, t1, t2, d, psum;
    logic lsb;
    s = 16'hACE1;
    k = 0;
    psum = 0;
    check("R7 set pulse count", cap_n, NSET);
    for (int st = 0; st < NSET; st++) begin
      pk = 0; sm = 0; sq = 0;
      for (int i = 0; i < NS; i++) begin
        t1 = sat(per(pat, k));
        t2 = sat(per(pat, k + 1));
        k += 2;
        d = (t1 > t2) ? t1 - t2 : t2 - t1;
        if (d > pk) pk = d;
        sm += d;
        sq += d * d;
        if (!(st == NSET - 1 && i == NS - 1)) begin
          k += int'(s[GW-1:0] & m);
          lsb = s[0];
          s = {1'b0, s[15:1]} ^ (lsb ? 16'hB400 : 16'h0000);
        end
      end
      psum += pk;
      check("R5 set peak", cap_peak[st], pk);
      check("R6 set sum", cap_sum[st], sm);
      check("R6 set sum of squares", cap_sq[st], sq);
      check("R6 set count", cap_cnt[st], NS);
    end
    check("R8 average peak", avg_peak, psum / NSET);
    check("R8 done high", done, 1);
  endtask

  task automatic check_long(input int pat);
    int span;
    span = 0;
    for (int k = 0; k < LT; k++) span += sat(per(pat, k));
    check("R9 accumulated span", lt_span, span);
    check("R9 done high", done, 1);
    check("R9 no set pulses", cap_n, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset done", done, 0);
    check("R1 reset set_vld", set_vld, 0);
    check("R1 reset ovf", ovf, 0);
    check("R1 reset avg", avg_peak, 0);
    check("R1 reset span", lt_span, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 R5 R6: back-to-back samples
    run(0, 1'b0, 8'h00);
    check_sampled(0, 8'h00);
    repeat (5) @(negedge clk);
    check("R8 done holds without start", done, 1);

    // R4: random gaps
    run(1, 1'b0, 8'h07);
    check_sampled(1, 8'h07);
    check("R3 no ovf for short periods", ovf, 0);

    run(1, 1'b0, 8'h1B);
    check_sampled(1, 8'h1B);

    // R9: contiguous run
    run(2, 1'b1, 8'h00);
    check_long(2);

    // R3: saturating period in the contiguous run
    run(3, 1'b1, 8'h00);
    check_long(3);
    check("R3 ovf set", ovf, 1);
    repeat (5) @(negedge clk);
    check("R3 ovf sticky", ovf, 1);

    // R1 R3: restart clears ovf
    run(0, 1'b0, 8'h00);
    check_sampled(0, 8'h00);
    check("R3 ovf cleared by start", ovf, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule